// File: doc/BRIEF.md
# Banked Shared-Memory Bridge with Mailbox Bytes

This block sits between a local controller and a host processor. The two of them share one external SRAM and three message bytes. Each processor sees a 1 KB window into the SRAM. A bank register, which only the local controller can write, picks which of eight 1 KB banks the window shows. Both sides use the same bank, so the host sees whichever bank the controller selected last. Three one-byte mailbox registers carry commands and status between the two processors. Either side can read or write any of them. The local controller can also read a private 8 KB ROM region, which has no host-side mapping at all.

Each side issues requests on a valid/ready channel. The host channel never back-pressures; `hst_req_ready` is always high. The local channel is held off (`lcl_req_ready` low) for one cycle whenever both sides reach for the SRAM window in the same cycle. The local requester must then keep its request steady until it is accepted. Each accepted read returns exactly one response beat on `*_rsp_valid`/`*_rsp_data`. Writes return nothing. The response channel has no ready: the requester must take the beat in the cycle it appears. The external SRAM and ROM are synchronous, with one cycle of read latency.

Top module: `shmem_mbox_bridge`

## Requirements
- R1: After reset every mailbox byte reads 0x00, the bank register selects bank 0, and neither response valid is high.
- R2: Local addresses 0x1000–0x13FF and host offsets 0x000–0x3FF both reach SRAM address {bank, addr[9:0]}. Reads and writes through either side hit the same byte.
- R3: A local write of 0xF0+n (n = 0..7) to address 0x1600 selects bank n. A local read of 0x1600 returns 0xF0+bank.
- R4: A local write to 0x1600 of any value whose upper five bits are not 11110 leaves the bank unchanged.
- R5: The mailbox bytes sit at local 0x1401–0x1403 and host 0x401–0x403, byte k at base+k. A read returns the value held before any write in the same cycle.
- R6: When both sides write the same mailbox byte in the same cycle, the host value is kept. When they write different bytes, both writes land.
- R7: When both sides request the SRAM window in the same cycle, the host is served and `lcl_req_ready` is low in that cycle. A local request held steady is served in the next cycle that has no host window access.
- R8: Local reads of 0x2000–0x3FFF return ROM data at offset addr[12:0]. Local writes there change nothing. The ROM enable is never driven by a host access.
- R9: Host reads of offsets 0x400 and 0x404–0x7FF return 0xFF, and host writes there change nothing. Local reads of addresses outside the window, mailbox, bank register and ROM return 0xFF.
- R10: While `hst_mbox_block` is high, host mailbox reads return 0xFF and host mailbox writes are dropped. Local mailbox accesses are unaffected.
- R11: `*_rsp_valid` is high in exactly the cycle after each accepted read, and is low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_req_valid | input | 1 | Local request present |
| lcl_req_ready | output | 1 | Local request accepted this cycle |
| lcl_req_we | input | 1 | Local request is a write |
| lcl_req_addr | input | 16 | Local byte address |
| lcl_req_wdata | input | 8 | Local write data |
| lcl_rsp_valid | output | 1 | Local read data present |
| lcl_rsp_data | output | 8 | Local read data |
| hst_req_valid | input | 1 | Host request present |
| hst_req_ready | output | 1 | Host request accepted (always high) |
| hst_req_we | input | 1 | Host request is a write |
| hst_req_addr | input | 11 | Host byte offset |
| hst_req_wdata | input | 8 | Host write data |
| hst_rsp_valid | output | 1 | Host read data present |
| hst_rsp_data | output | 8 | Host read data |
| hst_mbox_block | input | 1 | Blocks host access to the mailbox bytes |
| sram_en | output | 1 | External SRAM access strobe |
| sram_we | output | 1 | External SRAM write |
| sram_addr | output | 13 | External SRAM address {bank, offset} |
| sram_wdata | output | 8 | External SRAM write data |
| sram_rdata | input | 8 | External SRAM read data, one cycle after strobe |
| rom_en | output | 1 | Private ROM read strobe |
| rom_addr | output | 13 | Private ROM address |
| rom_rdata | input | 8 | Private ROM data, one cycle after strobe |

## Verification
Every result is due one cycle after the rising edge that accepts the request. A read's data and valid appear after that edge and hold until the next one. A mailbox or bank write becomes visible to a read accepted on the following edge. Bank changes reach the window on that same following edge. The bench drives each request at a falling edge and waits through exactly one rising edge. It then samples the response at the next falling edge. Readiness is sampled just after driving, before the accepting edge. Collision cases drive both ports in the same cycle so that the host-first and host-wins rules meet in a single edge.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_WIN  = 3'd1,
    RG_MBOX = 3'd2,
    RG_BANK = 3'd3,
    RG_ROM  = 3'd4
  } smb_region_e;

  typedef enum logic [1:0] {
    SRC_SRAM = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_HOLD = 2'd2
  } smb_src_e;
endpackage

// File: rtl/smb_addr_decode.sv
module smb_addr_decode
  import smb_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned WIN_BASE  = 32'h1000,
  parameter int unsigned WIN_AW    = 10,
  parameter int unsigned MBOX_BASE = 32'h1401,
  parameter int unsigned N_MBOX    = 3,
  parameter int unsigned IDX_W     = 2,
  parameter bit          HAS_BANK  = 1'b1,
  parameter int unsigned BANK_ADDR = 32'h1600,
  parameter bit          HAS_ROM   = 1'b1,
  parameter int unsigned ROM_BASE  = 32'h2000,
  parameter int unsigned ROM_AW    = 13
) (
  input  logic [AW-1:0]    addr,
  output smb_region_e      region,
  output logic [IDX_W-1:0] mbox_idx
);
  localparam int unsigned WIN_END  = WIN_BASE + (32'd1 << WIN_AW);
  localparam int unsigned MBOX_END = MBOX_BASE + N_MBOX;

  logic [31:0] a32;
  logic        win_hit, mbox_hit, bank_hit, rom_hit;

  assign a32      = 32'(addr);
  assign win_hit  = (a32 >= WIN_BASE) && (a32 < WIN_END);
  assign mbox_hit = (a32 >= MBOX_BASE) && (a32 < MBOX_END);
  assign mbox_idx = IDX_W'(a32 - MBOX_BASE);

  generate
    if (HAS_BANK) begin : g_bank
      assign bank_hit = (a32 == BANK_ADDR);
    end else begin : g_no_bank
      assign bank_hit = 1'b0;
    end
    if (HAS_ROM) begin : g_rom
      localparam int unsigned ROM_END = ROM_BASE + (32'd1 << ROM_AW);
      assign rom_hit = (a32 >= ROM_BASE) && (a32 < ROM_END);
    end else begin : g_no_rom
      assign rom_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    if (win_hit)       region = RG_WIN;
    else if (mbox_hit) region = RG_MBOX;
    else if (bank_hit) region = RG_BANK;
    else if (rom_hit)  region = RG_ROM;
    else               region = RG_NONE;
  end
endmodule

// File: rtl/smb_mailbox.sv
module smb_mailbox #(
  parameter int unsigned DW     = 8,
  parameter int unsigned N_MBOX = 3,
  parameter int unsigned IDX_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       l_we,
  input  logic [IDX_W-1:0]           l_idx,
  input  logic [DW-1:0]              l_wdata,
  input  logic                       h_we,
  input  logic [IDX_W-1:0]           h_idx,
  input  logic [DW-1:0]              h_wdata,
  output logic [N_MBOX-1:0][DW-1:0]  q
);
  generate
    for (genvar k = 0; k < N_MBOX; k++) begin : g_byte
      logic l_hit, h_hit;
      assign l_hit = l_we && (l_idx == IDX_W'(k));
      assign h_hit = h_we && (h_idx == IDX_W'(k));
      always_ff @(posedge clk) begin
        if (!rst_n)     q[k] <= '0;
        else if (h_hit) q[k] <= h_wdata;
        else if (l_hit) q[k] <= l_wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/smb_bank_reg.sv
module smb_bank_reg #(
  parameter int unsigned    DW       = 8,
  parameter int unsigned    BANK_W   = 3,
  parameter logic [DW-1:0]  BANK_KEY = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  output logic [BANK_W-1:0] bank,
  output logic [DW-1:0]     readback
);
  localparam logic [DW-BANK_W-1:0] KEY_HI = BANK_KEY[DW-1:BANK_W];

  logic key_ok;
  assign key_ok   = (wdata[DW-1:BANK_W] == KEY_HI);
  assign readback = {KEY_HI, bank};

  always_ff @(posedge clk) begin
    if (!rst_n)            bank <= '0;
    else if (we && key_ok) bank <= wdata[BANK_W-1:0];
  end
endmodule

// File: rtl/smb_rsp_port.sv
module smb_rsp_port
  import smb_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_acc,
  input  smb_src_e      src,
  input  logic [DW-1:0] hold_data,
  input  logic [DW-1:0] sram_rdata,
  input  logic [DW-1:0] rom_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  smb_src_e      src_q;
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      src_q     <= SRC_HOLD;
      hold_q    <= '1;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) begin
        src_q  <= src;
        hold_q <= hold_data;
      end
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_SRAM: rsp_data = sram_rdata;
      SRC_ROM:  rsp_data = rom_rdata;
      default:  rsp_data = hold_q;
    endcase
  end
endmodule

// File: rtl/shmem_mbox_bridge.sv
module shmem_mbox_bridge
  import smb_pkg::*;
#(
  parameter int unsigned   DW            = 8,
  parameter int unsigned   LCL_AW        = 16,
  parameter int unsigned   HST_AW        = 11,
  parameter int unsigned   WIN_AW        = 10,
  parameter int unsigned   BANK_W        = 3,
  parameter int unsigned   N_MBOX        = 3,
  parameter int unsigned   ROM_AW        = 13,
  parameter int unsigned   LCL_WIN_BASE  = 32'h1000,
  parameter int unsigned   LCL_MBOX_BASE = 32'h1401,
  parameter int unsigned   LCL_BANK_ADDR = 32'h1600,
  parameter int unsigned   LCL_ROM_BASE  = 32'h2000,
  parameter int unsigned   HST_MBOX_BASE = 32'h401,
  parameter logic [DW-1:0] BANK_KEY      = 8'hF0,
  localparam int unsigned  SRAM_AW       = WIN_AW + BANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lcl_req_valid,
  output logic               lcl_req_ready,
  input  logic               lcl_req_we,
  input  logic [LCL_AW-1:0]  lcl_req_addr,
  input  logic [DW-1:0]      lcl_req_wdata,
  output logic               lcl_rsp_valid,
  output logic [DW-1:0]      lcl_rsp_data,
  input  logic               hst_req_valid,
  output logic               hst_req_ready,
  input  logic               hst_req_we,
  input  logic [HST_AW-1:0]  hst_req_addr,
  input  logic [DW-1:0]      hst_req_wdata,
  output logic               hst_rsp_valid,
  output logic [DW-1:0]      hst_rsp_data,
  input  logic               hst_mbox_block,
  output logic               sram_en,
  output logic               sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [DW-1:0]      sram_wdata,
  input  logic [DW-1:0]      sram_rdata,
  output logic               rom_en,
  output logic [ROM_AW-1:0]  rom_addr,
  input  logic [DW-1:0]      rom_rdata
);
  localparam int unsigned IDX_W = (N_MBOX > 1) ? $clog2(N_MBOX) : 1;

  smb_region_e               l_rg, h_rg;
  logic [IDX_W-1:0]          l_idx, h_idx;
  logic [BANK_W-1:0]         bank_sel;
  logic [DW-1:0]             bank_rb;
  logic [N_MBOX-1:0][DW-1:0] mbox_q;
  logic                      l_win, h_win, l_acc, h_acc;
  logic                      l_mbox_we, h_mbox_we, bank_we;
  logic [DW-1:0]             l_mbox_rd, h_mbox_rd, l_hold, h_hold;
  smb_src_e                  l_src, h_src;

  smb_addr_decode #(
    .AW(LCL_AW), .WIN_BASE(LCL_WIN_BASE), .WIN_AW(WIN_AW),
    .MBOX_BASE(LCL_MBOX_BASE), .N_MBOX(N_MBOX), .IDX_W(IDX_W),
    .HAS_BANK(1'b1), .BANK_ADDR(LCL_BANK_ADDR),
    .HAS_ROM(1'b1), .ROM_BASE(LCL_ROM_BASE), .ROM_AW(ROM_AW)
  ) u_lcl_dec (
    .addr(lcl_req_addr), .region(l_rg), .mbox_idx(l_idx)
  );

  smb_addr_decode #(
    .AW(HST_AW), .WIN_BASE(32'h0), .WIN_AW(WIN_AW),
    .MBOX_BASE(HST_MBOX_BASE), .N_MBOX(N_MBOX), .IDX_W(IDX_W),
    .HAS_BANK(1'b0), .BANK_ADDR(32'h0),
    .HAS_ROM(1'b0), .ROM_BASE(32'h0), .ROM_AW(ROM_AW)
  ) u_hst_dec (
    .addr(hst_req_addr), .region(h_rg), .mbox_idx(h_idx)
  );

  // Window arbitration: the host always takes the single SRAM port.
  assign l_win         = lcl_req_valid && (l_rg == RG_WIN);
  assign h_win         = hst_req_valid && (h_rg == RG_WIN);
  assign lcl_req_ready = !(l_win && h_win);
  assign hst_req_ready = 1'b1;
  assign l_acc         = lcl_req_valid && lcl_req_ready;
  assign h_acc         = hst_req_valid;

  always_comb begin
    sram_en    = 1'b0;
    sram_we    = 1'b0;
    sram_addr  = '0;
    sram_wdata = '0;
    if (h_win) begin
      sram_en    = 1'b1;
      sram_we    = hst_req_we;
      sram_addr  = {bank_sel, hst_req_addr[WIN_AW-1:0]};
      sram_wdata = hst_req_wdata;
    end else if (l_win) begin
      sram_en    = 1'b1;
      sram_we    = lcl_req_we;
      sram_addr  = {bank_sel, lcl_req_addr[WIN_AW-1:0]};
      sram_wdata = lcl_req_wdata;
    end
  end

  assign rom_en   = l_acc && !lcl_req_we && (l_rg == RG_ROM);
  assign rom_addr = lcl_req_addr[ROM_AW-1:0];

  assign bank_we   = l_acc && lcl_req_we && (l_rg == RG_BANK);
  assign l_mbox_we = l_acc && lcl_req_we && (l_rg == RG_MBOX);
  assign h_mbox_we = h_acc && hst_req_we && (h_rg == RG_MBOX) && !hst_mbox_block;

  smb_bank_reg #(.DW(DW), .BANK_W(BANK_W), .BANK_KEY(BANK_KEY)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .wdata(lcl_req_wdata),
    .bank(bank_sel), .readback(bank_rb)
  );

  smb_mailbox #(.DW(DW), .N_MBOX(N_MBOX), .IDX_W(IDX_W)) u_mbox (
    .clk(clk), .rst_n(rst_n),
    .l_we(l_mbox_we), .l_idx(l_idx), .l_wdata(lcl_req_wdata),
    .h_we(h_mbox_we), .h_idx(h_idx), .h_wdata(hst_req_wdata),
    .q(mbox_q)
  );

  always_comb begin
    l_mbox_rd = '1;
    h_mbox_rd = '1;
    for (int k = 0; k < N_MBOX; k++) begin
      if (l_idx == IDX_W'(k)) l_mbox_rd = mbox_q[k];
      if (h_idx == IDX_W'(k)) h_mbox_rd = mbox_q[k];
    end
  end

  always_comb begin
    l_src  = SRC_HOLD;
    l_hold = '1;
    unique case (l_rg)
      RG_WIN:  l_src  = SRC_SRAM;
      RG_ROM:  l_src  = SRC_ROM;
      RG_MBOX: l_hold = l_mbox_rd;
      RG_BANK: l_hold = bank_rb;
      default: l_hold = '1;
    endcase
  end

  always_comb begin
    h_src  = SRC_HOLD;
    h_hold = '1;
    if (h_rg == RG_WIN)                         h_src  = SRC_SRAM;
    else if (h_rg == RG_MBOX && !hst_mbox_block) h_hold = h_mbox_rd;
  end

  smb_rsp_port #(.DW(DW)) u_lcl_rsp (
    .clk(clk), .rst_n(rst_n), .rd_acc(l_acc && !lcl_req_we),
    .src(l_src), .hold_data(l_hold),
    .sram_rdata(sram_rdata), .rom_rdata(rom_rdata),
    .rsp_valid(lcl_rsp_valid), .rsp_data(lcl_rsp_data)
  );

  smb_rsp_port #(.DW(DW)) u_hst_rsp (
    .clk(clk), .rst_n(rst_n), .rd_acc(h_acc && !hst_req_we),
    .src(h_src), .hold_data(h_hold),
    .sram_rdata(sram_rdata), .rom_rdata(rom_rdata),
    .rsp_valid(hst_rsp_valid), .rsp_data(hst_rsp_data)
  );
endmodule

// File: rtl/smb_bridge_chk.sv
module smb_bridge_chk #(
  parameter int unsigned DW            = 8,
  parameter int unsigned LCL_AW        = 16,
  parameter int unsigned HST_AW        = 11,
  parameter int unsigned WIN_AW        = 10,
  parameter int unsigned BANK_W        = 3,
  parameter int unsigned SRAM_AW       = 13,
  parameter int unsigned LCL_WIN_BASE  = 32'h1000,
  parameter int unsigned LCL_BANK_ADDR = 32'h1600,
  parameter int unsigned LCL_ROM_BASE  = 32'h2000,
  parameter int unsigned ROM_SPAN      = 32'h2000,
  parameter int unsigned HST_MBOX_BASE = 32'h401,
  parameter int unsigned N_MBOX        = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lcl_req_valid,
  input logic               lcl_req_ready,
  input logic               lcl_req_we,
  input logic [LCL_AW-1:0]  lcl_req_addr,
  input logic [DW-1:0]      lcl_req_wdata,
  input logic               lcl_rsp_valid,
  input logic               hst_req_valid,
  input logic               hst_req_we,
  input logic [HST_AW-1:0]  hst_req_addr,
  input logic               hst_rsp_valid,
  input logic [DW-1:0]      hst_rsp_data,
  input logic               hst_mbox_block,
  input logic               sram_en,
  input logic [SRAM_AW-1:0] sram_addr,
  input logic               rom_en,
  input logic [BANK_W-1:0]  bank
);
  logic l_in_win, h_in_win, h_in_mbox, h_hole, l_in_rom, l_bank_wr, key_ok, h_rd, l_rd;

  assign l_in_win  = (32'(lcl_req_addr) >= LCL_WIN_BASE) &&
                     (32'(lcl_req_addr) < LCL_WIN_BASE + (32'd1 << WIN_AW));
  assign h_in_win  = (32'(hst_req_addr) < (32'd1 << WIN_AW));
  assign h_in_mbox = (32'(hst_req_addr) >= HST_MBOX_BASE) &&
                     (32'(hst_req_addr) < HST_MBOX_BASE + N_MBOX);
  assign h_hole    = !h_in_win && !h_in_mbox;
  assign l_in_rom  = (32'(lcl_req_addr) >= LCL_ROM_BASE) &&
                     (32'(lcl_req_addr) < LCL_ROM_BASE + ROM_SPAN);
  assign l_bank_wr = lcl_req_valid && lcl_req_ready && lcl_req_we &&
                     (32'(lcl_req_addr) == LCL_BANK_ADDR);
  assign key_ok    = (lcl_req_wdata[DW-1:BANK_W] == {(DW-BANK_W-1){1'b1}} << 1);
  assign h_rd      = hst_req_valid && !hst_req_we;
  assign l_rd      = lcl_req_valid && lcl_req_ready && !lcl_req_we;

  AST_BANK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (l_bank_wr && !key_ok) |=> $stable(bank)); // R4
  AST_BANK_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (l_bank_wr && key_ok) |=> (bank == $past(lcl_req_wdata[BANK_W-1:0]))); // R3
  AST_HOST_WIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_req_valid && l_in_win && hst_req_valid && h_in_win) |-> !lcl_req_ready); // R7
  AST_SRAM_HOST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_req_valid && h_in_win) |-> (sram_en && sram_addr == {bank, hst_req_addr[WIN_AW-1:0]})); // R2
  AST_ROM_LOCAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> (lcl_req_valid && lcl_req_ready && !lcl_req_we && l_in_rom)); // R8
  AST_HST_RSP_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    h_rd |=> hst_rsp_valid); // R11
  AST_HST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rd |=> !hst_rsp_valid); // R11
  AST_LCL_RSP_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    l_rd |=> lcl_rsp_valid); // R11
  AST_BLOCKED_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_in_mbox && hst_mbox_block) |=> (hst_rsp_data == '1)); // R10
  AST_HOST_HOLE_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_hole) |=> (hst_rsp_data == '1)); // R9
endmodule

bind shmem_mbox_bridge smb_bridge_chk #(
  .DW(DW), .LCL_AW(LCL_AW), .HST_AW(HST_AW), .WIN_AW(WIN_AW), .BANK_W(BANK_W),
  .SRAM_AW(SRAM_AW), .LCL_WIN_BASE(LCL_WIN_BASE), .LCL_BANK_ADDR(LCL_BANK_ADDR),
  .LCL_ROM_BASE(LCL_ROM_BASE), .ROM_SPAN(32'd1 << ROM_AW),
  .HST_MBOX_BASE(HST_MBOX_BASE), .N_MBOX(N_MBOX)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lcl_req_valid(lcl_req_valid), .lcl_req_ready(lcl_req_ready),
  .lcl_req_we(lcl_req_we), .lcl_req_addr(lcl_req_addr),
  .lcl_req_wdata(lcl_req_wdata), .lcl_rsp_valid(lcl_rsp_valid),
  .hst_req_valid(hst_req_valid), .hst_req_we(hst_req_we),
  .hst_req_addr(hst_req_addr), .hst_rsp_valid(hst_rsp_valid),
  .hst_rsp_data(hst_rsp_data), .hst_mbox_block(hst_mbox_block),
  .sram_en(sram_en), .sram_addr(sram_addr), .rom_en(rom_en), .bank(bank_sel)
);

// File: tb/tb_shmem_mbox_bridge.sv
`timescale 1ns/100ps
module tb_shmem_mbox_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lcl_req_valid = 1'b0, lcl_req_we = 1'b0;
  logic [15:0] lcl_req_addr = '0;
  logic [7:0]  lcl_req_wdata = '0;
  logic        lcl_req_ready, lcl_rsp_valid;
  logic [7:0]  lcl_rsp_data;
  logic        hst_req_valid = 1'b0, hst_req_we = 1'b0;
  logic [10:0] hst_req_addr = '0;
  logic [7:0]  hst_req_wdata = '0;
  logic        hst_req_ready, hst_rsp_valid;
  logic [7:0]  hst_rsp_data;
  logic        hst_mbox_block = 1'b0;
  logic        sram_en, sram_we, rom_en;
  logic [12:0] sram_addr, rom_addr;
  logic [7:0]  sram_wdata, sram_rdata, rom_rdata;

  int n_checks = 0;
  int n_bad    = 0;
  bit finished = 1'b0;
  logic lrdy;

  always #2.5 clk = ~clk;

  shmem_mbox_bridge dut (
    .clk(clk), .rst_n(rst_n),
    .lcl_req_valid(lcl_req_valid), .lcl_req_ready(lcl_req_ready),
    .lcl_req_we(lcl_req_we), .lcl_req_addr(lcl_req_addr), .lcl_req_wdata(lcl_req_wdata),
    .lcl_rsp_valid(lcl_rsp_valid), .lcl_rsp_data(lcl_rsp_data),
    .hst_req_valid(hst_req_valid), .hst_req_ready(hst_req_ready),
    .hst_req_we(hst_req_we), .hst_req_addr(hst_req_addr), .hst_req_wdata(hst_req_wdata),
    .hst_rsp_valid(hst_rsp_valid), .hst_rsp_data(hst_rsp_data),
    .hst_mbox_block(hst_mbox_block),
    .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_rdata)
  );

  // External memory models: synchronous, one cycle read latency.
  logic [7:0] mem [0:8191];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 8192; a++) mem[a] <= 8'(a) ^ {3'b000, 5'(a >> 8)};
      sram_rdata <= 8'h00;
    end else if (sram_en) begin
      if (sram_we) mem[sram_addr] <= sram_wdata;
      else         sram_rdata <= mem[sram_addr];
    end
  end
  always @(posedge clk) begin
    if (rom_en) rom_rdata <= ~rom_addr[7:0] ^ {3'b000, rom_addr[12:8]};
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, accept at rising edge, sample at next falling edge.
  task automatic cyc(input logic lv, input logic lw, input logic [15:0] la, input logic [7:0] ld,
                     input logic hv, input logic hw, input logic [10:0] ha, input logic [7:0] hd);
    lcl_req_valid = lv; lcl_req_we = lw; lcl_req_addr = la; lcl_req_wdata = ld;
    hst_req_valid = hv; hst_req_we = hw; hst_req_addr = ha; hst_req_wdata = hd;
    #1 lrdy = lcl_req_ready;
    @(posedge clk);
    @(negedge clk);
    lcl_req_valid = 1'b0; hst_req_valid = 1'b0;
  endtask

  // {req id[3:0], host, we, pad[1:0], addr[15:0], wdata[7:0], expected[7:0]}
  localparam int NV = 25;
  localparam logic [39:0] VEC [0:NV-1] = '{
    {4'd3,  1'b0, 1'b1, 2'b0, 16'h1600, 8'hF3, 8'h00},
    {4'd3,  1'b0, 1'b0, 2'b0, 16'h1600, 8'h00, 8'hF3},
    {4'd2,  1'b0, 1'b1, 2'b0, 16'h1010, 8'h5A, 8'h00},
    {4'd2,  1'b0, 1'b0, 2'b0, 16'h1010, 8'h00, 8'h5A},
    {4'd2,  1'b1, 1'b0, 2'b0, 16'h0010, 8'h00, 8'h5A},
    {4'd4,  1'b0, 1'b1, 2'b0, 16'h1600, 8'h42, 8'h00},
    {4'd4,  1'b0, 1'b0, 2'b0, 16'h1600, 8'h00, 8'hF3},
    {4'd4,  1'b0, 1'b1, 2'b0, 16'h1600, 8'hF8, 8'h00},
    {4'd4,  1'b0, 1'b0, 2'b0, 16'h1600, 8'h00, 8'hF3},
    {4'd3,  1'b0, 1'b1, 2'b0, 16'h1600, 8'hF0, 8'h00},
    {4'd3,  1'b0, 1'b0, 2'b0, 16'h1010, 8'h00, 8'h10},
    {4'd5,  1'b1, 1'b1, 2'b0, 16'h0402, 8'h77, 8'h00},
    {4'd5,  1'b0, 1'b0, 2'b0, 16'h1402, 8'h00, 8'h77},
    {4'd5,  1'b0, 1'b1, 2'b0, 16'h1403, 8'hC1, 8'h00},
    {4'd5,  1'b1, 1'b0, 2'b0, 16'h0403, 8'h00, 8'hC1},
    {4'd8,  1'b0, 1'b0, 2'b0, 16'h2005, 8'h00, 8'hFA},
    {4'd8,  1'b0, 1'b0, 2'b0, 16'h3FFF, 8'h00, 8'h1F},
    {4'd8,  1'b0, 1'b1, 2'b0, 16'h2005, 8'h99, 8'h00},
    {4'd8,  1'b0, 1'b0, 2'b0, 16'h2005, 8'h00, 8'hFA},
    {4'd9,  1'b1, 1'b0, 2'b0, 16'h0400, 8'h00, 8'hFF},
    {4'd9,  1'b1, 1'b0, 2'b0, 16'h07FF, 8'h00, 8'hFF},
    {4'd9,  1'b0, 1'b0, 2'b0, 16'h1400, 8'h00, 8'hFF},
    {4'd9,  1'b1, 1'b1, 2'b0, 16'h0500, 8'h33, 8'h00},
    {4'd9,  1'b1, 1'b0, 2'b0, 16'h0401, 8'h00, 8'h00},
    {4'd2,  1'b1, 1'b1, 2'b0, 16'h03FF, 8'hAB, 8'h00}
  };

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_checks++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held in reset, then after release
    check("R1 lcl_rsp_valid", {7'b0, lcl_rsp_valid}, 8'h00);
    check("R1 hst_rsp_valid", {7'b0, hst_rsp_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 1; k <= 3; k++) begin
      cyc(1'b1, 1'b0, 16'h1400 + 16'(k), 8'h00, 1'b0, 1'b0, 11'h0, 8'h00);
      check("R1 mailbox cleared", lcl_rsp_data, 8'h00);
    end
    cyc(1'b1, 1'b0, 16'h1600, 8'h00, 1'b0, 1'b0, 11'h0, 8'h00);
    check("R1 bank zero", lcl_rsp_data, 8'hF0);

    // Vector table, one side per vector.
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[39:36], i);
      if (v[35])
        cyc(1'b0, 1'b0, 16'h0, 8'h00, 1'b1, v[34], v[26:16], v[15:8]);
      else
        cyc(1'b1, v[34], v[31:16], v[15:8], 1'b0, 1'b0, 11'h0, 8'h00);
      if (v[34]) begin
        check({tag, " R11 no rsp after write"},
              {7'b0, (v[35] ? hst_rsp_valid : lcl_rsp_valid)}, 8'h00);
      end else begin
        check({tag, " R11 rsp valid"}, {7'b0, (v[35] ? hst_rsp_valid : lcl_rsp_valid)}, 8'h01);
        check(tag, v[35] ? hst_rsp_data : lcl_rsp_data, v[7:0]);
      end
    end
    // Host window write above lands in bank 0 offset 0x3FF (R2).
    cyc(1'b1, 1'b0, 16'h13FF, 8'h00, 1'b0, 1'b0, 11'h0, 8'h00);
    check("R2 host write seen locally", lcl_rsp_data, 8'hAB);

    // R6: same-byte write collision, then different bytes.
    cyc(1'b1, 1'b1, 16'h1401, 8'h22, 1'b1, 1'b1, 11'h401, 8'h11);
    cyc(1'b1, 1'b0, 16'h1401, 8'h00, 1'b0, 1'b0, 11'h0, 8'h00);
    check("R6 host wins", lcl_rsp_data, 8'h11);
    cyc(1'b1, 1'b1, 16'h1402, 8'h55, 1'b1, 1'b1, 11'h401, 8'h44);
    cyc(1'b1, 1'b0, 16'h1401, 8'h00, 1'b1, 1'b0, 11'h402, 8'h00);
    check("R6 host byte", lcl_rsp_data, 8'h44);
    check("R6 local byte", hst_rsp_data, 8'h55);

    // R5: read returns the value held before a same-cycle write.
    cyc(1'b1, 1'b1, 16'h1402, 8'h66, 1'b1, 1'b0, 11'h402, 8'h00);
    check("R5 read before write", hst_rsp_data, 8'h55);
    cyc(1'b0, 1'b0, 16'h0, 8'h00, 1'b1, 1'b0, 11'h402, 8'h00);
    check("R5 write landed", hst_rsp_data, 8'h66);

    // R7: window collision, host first, local retries.
    cyc(1'b1, 1'b0, 16'h1020, 8'h00, 1'b1, 1'b0, 11'h030, 8'h00);
    check("R7 local held off", {7'b0, lrdy}, 8'h00);
    check("R7 host served", hst_rsp_data, 8'h30);
    check("R7 no local rsp", {7'b0, lcl_rsp_valid}, 8'h00);
    cyc(1'b1, 1'b0, 16'h1020, 8'h00, 1'b0, 1'b0, 11'h0, 8'h00);
    check("R7 local ready on retry", {7'b0, lrdy}, 8'h01);
    check("R7 local served", lcl_rsp_data, 8'h20);

    // R10: host mailbox blocked.
    hst_mbox_block = 1'b1;
    cyc(1'b0, 1'b0, 16'h0, 8'h00, 1'b1, 1'b0, 11'h401, 8'h00);
    check("R10 blocked read", hst_rsp_data, 8'hFF);
    cyc(1'b1, 1'b1, 16'h1403, 8'h12, 1'b1, 1'b1, 11'h401, 8'hEE);
    cyc(1'b1, 1'b0, 16'h1401, 8'h00, 1'b0, 1'b0, 11'h0, 8'h00);
    check("R10 blocked write dropped", lcl_rsp_data, 8'h44);
    hst_mbox_block = 1'b0;
    cyc(1'b0, 1'b0, 16'h0, 8'h00, 1'b1, 1'b0, 11'h403, 8'h00);
    check("R10 local write still works", hst_rsp_data, 8'h12);

    // R11: idle cycle leaves both responses low.
    cyc(1'b0, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0, 11'h0, 8'h00);
    check("R11 idle", {6'b0, lcl_rsp_valid, hst_rsp_valid}, 8'h00);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule